// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block holds the data-hazard decisions for a five-stage in-order integer pipeline. Each cycle it sees the instruction in decode: its two source register numbers, whether each source is actually read, and its own destination, write-enable and load flag. It keeps a short record of the destinations of the two instructions ahead of it, in execute and in memory. From that record it picks, ahead of time, where each ALU operand should come from once the decoded instruction reaches execute. The choices are the register file, the result leaving the memory stage, or the result in the writeback stage.

A result that a load has not yet fetched cannot be bypassed into the very next instruction. When decode depends on a load sitting in execute, the block raises `stall` to hold fetch and decode, and raises `bubble` so that execute takes a no-op on the same edge. One cycle later the load has moved on, and the held instruction proceeds with its operand taken from the writeback stage. Writebacks retire in order at the last stage, and the register file passes a value written in a cycle through to a read in that same cycle. Because of that, only read-after-write cases against the two nearer stages need handling.

Top module: `fwd_stall_unit`

## Requirements
- R1: Operand select codes are 0 = register file, 1 = memory-stage result, 2 = writeback-stage result; code 3 never appears. When the instruction just ahead of decode writes a register that decode reads, that operand's select is 1 in the cycle after the edge that moves decode into execute.
- R2: When only the instruction two ahead of decode writes the register that decode reads, that operand's select is 2 in the cycle after decode moves to execute.
- R3: When both older instructions write the same source register, the nearer one wins and the select is 1.
- R4: Register 0 is never bypassed (select 0) and never causes a stall, even when an older instruction names it as a write-enabled destination or a load target.
- R5: An older instruction without write enable, or an empty slot, is never matched. A source whose use flag is low selects 0 and cannot stall. A decode slot with its valid bit low never stalls, and the execute slot it feeds selects 0 for both operands.
- R6: When decode is valid and reads a nonzero register that a load in execute will write, `stall` and `bubble` are both high in that same cycle, combinationally from the inputs.
- R7: A load-use stall lasts exactly one cycle. The edge that ends it places a no-op in execute, so both selects read 0 for that cycle. When the held instruction then advances, its dependent operand selects 2.
- R8: Reset, asserted at any time, drives both selects to 0, deasserts `stall` and `bubble`, and clears the record of older destinations, so no instruction after reset is bypassed from an instruction before it.
- R9: An instruction three ahead of decode (already past writeback) is never bypassed; its result is read from the register file (select 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_rs | input | REG_AW | First source register number in decode |
| dec_rt | input | REG_AW | Second source register number in decode |
| dec_use_rs | input | 1 | First source is read by this instruction |
| dec_use_rt | input | 1 | Second source is read by this instruction |
| dec_wen | input | 1 | Decoded instruction writes a register |
| dec_load | input | 1 | Decoded instruction is a load |
| dec_rd | input | REG_AW | Destination register number in decode |
| fwd_a | output | 2 | Select for first ALU operand of the instruction in execute |
| fwd_b | output | 2 | Select for second ALU operand of the instruction in execute |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Load a no-op into execute on this edge |

## Verification
The bench builds the block with its default register-number width of five bits, i.e. a 32-entry register file. At that width, one short program can reuse distinct registers to separate the one-ahead, two-ahead and three-ahead distances while still reaching register 0 and high register numbers. A bench-side record of the pipeline drives each vector, including the repeated decode slot after a stall. The directed part resets while a producer is in flight. Together these cover priority between the two nearer stages, suppression for register 0, unused sources and non-writers, and the single-cycle interlock on either operand.

// File: rtl/fwd_stall_pkg.sv
`timescale 1ns/1ps
package fwd_stall_pkg;

    // Operand source codes seen by the execute-stage muxes
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_MEM     = 2'd1,
        SRC_WB      = 2'd2
    } fwd_src_e;

    // ALU operands per instruction
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/fwd_src_sel.sv
`timescale 1ns/1ps
// Picks the source of one operand for the instruction about to enter execute.
// "near" is the instruction now in execute (in memory next cycle),
// "far" the one now in memory (in writeback next cycle).
module fwd_src_sel
    import fwd_stall_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              src_used,
    input  logic              near_live,
    input  logic [REG_AW-1:0] near_rd,
    input  logic              far_live,
    input  logic [REG_AW-1:0] far_rd,
    output logic [1:0]        sel
);
    logic src_nonzero;
    logic near_hit;
    logic far_hit;

    always_comb begin
        src_nonzero = |src;
        near_hit    = src_used && src_nonzero && near_live && (near_rd == src);
        far_hit     = src_used && src_nonzero && far_live  && (far_rd  == src);
        if (near_hit) begin
            sel = SRC_MEM;
        end else if (far_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/load_use_det.sv
`timescale 1ns/1ps
// Flags a decode instruction that reads the destination of a load in execute.
module load_use_det #(
    parameter int REG_AW = 5,
    parameter int N_SRC  = 2
) (
    input  logic                          dec_valid,
    input  logic [N_SRC-1:0][REG_AW-1:0]  srcs,
    input  logic [N_SRC-1:0]              uses,
    input  logic                          ex_live,
    input  logic                          ex_load,
    input  logic [REG_AW-1:0]             ex_rd,
    output logic                          hazard
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
        assign hit[i] = uses[i] && (|srcs[i]) && (srcs[i] == ex_rd);
    end

    assign hazard = dec_valid && ex_live && ex_load && (|hit);
endmodule

// File: rtl/fwd_stall_unit.sv
`timescale 1ns/1ps
module fwd_stall_unit
    import fwd_stall_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_rs,
    input  logic [REG_AW-1:0] dec_rt,
    input  logic              dec_use_rs,
    input  logic              dec_use_rt,
    input  logic              dec_wen,
    input  logic              dec_load,
    input  logic [REG_AW-1:0] dec_rd,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              stall,
    output logic              bubble
);
    localparam int NS = NUM_SRC;

    typedef struct packed {
        logic              live;
        logic              load;
        logic [REG_AW-1:0] rd;
    } ex_tag_t;

    typedef struct packed {
        logic              live;
        logic [REG_AW-1:0] rd;
    } mem_tag_t;

    typedef struct packed {
        ex_tag_t              ex;
        mem_tag_t             mem;
        logic [NS-1:0][1:0]   sel;
    } state_t;

    state_t st_d, st_q;

    logic [NS-1:0][REG_AW-1:0] srcs;
    logic [NS-1:0]             uses;
    logic [NS-1:0][1:0]        pick;
    logic                      hazard;

    assign srcs = {dec_rt, dec_rs};
    assign uses = {dec_use_rt, dec_use_rs};

    for (genvar i = 0; i < NS; i++) begin : g_op
        fwd_src_sel #(.REG_AW(REG_AW)) u_sel (
            .src       (srcs[i]),
            .src_used  (uses[i]),
            .near_live (st_q.ex.live),
            .near_rd   (st_q.ex.rd),
            .far_live  (st_q.mem.live),
            .far_rd    (st_q.mem.rd),
            .sel       (pick[i])
        );
    end

    load_use_det #(.REG_AW(REG_AW), .N_SRC(NS)) u_lud (
        .dec_valid (dec_valid),
        .srcs      (srcs),
        .uses      (uses),
        .ex_live   (st_q.ex.live),
        .ex_load   (st_q.ex.load),
        .ex_rd     (st_q.ex.rd),
        .hazard    (hazard)
    );

    always_comb begin
        st_d = st_q;
        // memory slot always takes whatever execute held
        st_d.mem.live = st_q.ex.live;
        st_d.mem.rd   = st_q.ex.rd;
        if (hazard || !dec_valid) begin
            // no-op enters execute
            st_d.ex = '0;
            for (int i = 0; i < NS; i++) begin
                st_d.sel[i] = SRC_REGFILE;
            end
        end else begin
            st_d.ex.live = dec_wen;
            st_d.ex.load = dec_load;
            st_d.ex.rd   = dec_rd;
            for (int i = 0; i < NS; i++) begin
                st_d.sel[i] = pick[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_a  = st_q.sel[0];
    assign fwd_b  = st_q.sel[1];
    assign stall  = hazard;
    assign bubble = hazard;
endmodule

// File: rtl/fwd_stall_chk.sv
`timescale 1ns/1ps
module fwd_stall_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [REG_AW-1:0] dec_rs,
    input logic [REG_AW-1:0] dec_rt,
    input logic              dec_use_rs,
    input logic              dec_use_rt,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              stall
);
    p_sel_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'd3) && (fwd_b != 2'd3));

    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !stall && (!dec_use_rs || dec_rs == '0)) |=> (fwd_a == 2'd0));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);

    p_idle_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

    p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((dec_use_rs && dec_rs != '0) || (dec_use_rt && dec_rt != '0)));

    p_stall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_post_stall_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fwd_a == 2'd0 && fwd_b == 2'd0));
endmodule

bind fwd_stall_unit fwd_stall_chk #(.REG_AW(REG_AW)) u_fwd_stall_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .dec_use_rs (dec_use_rs),
    .dec_use_rt (dec_use_rt),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .stall      (stall)
);

// File: tb/fwd_stall_unit_bench.sv
`timescale 1ns/1ps
module fwd_stall_unit_bench;
    localparam int AW = 5;
    localparam int VW = 25;
    localparam int NV = 24;

    // Entry: valid, use_rs, use_rt, wen, load, rs, rt, rd, exp_stall, exp_a, exp_b
    function automatic logic [VW-1:0] mk(input logic v, input logic urs, input logic urt,
                                         input logic w, input logic ld,
                                         input int rs, input int rt, input int rd,
                                         input logic st, input int a, input int b);
        mk = {v, urs, urt, w, ld, rs[AW-1:0], rt[AW-1:0], rd[AW-1:0], st, a[1:0], b[1:0]};
    endfunction

    localparam logic [VW-1:0] VEC [NV] = '{
        mk(1,1,1,1,0,  2, 3, 1, 0,0,0),  // no producers
        mk(1,1,1,1,0,  1, 3, 4, 0,1,0),  // R1 one ahead on rs
        mk(1,1,1,1,0,  7, 1, 6, 0,0,2),  // R2 two ahead on rt
        mk(1,1,1,1,0,  1, 4, 8, 0,0,2),  // R9 r1 three ahead -> regfile; r4 two ahead
        mk(1,1,1,1,0,  9, 9, 5, 0,0,0),
        mk(1,1,0,1,0,  5, 0, 5, 0,1,0),  // R1 rt unused
        mk(1,1,1,1,0,  5, 5,10, 0,1,1),  // R3 both stages write r5
        mk(1,1,1,1,0,  1, 1, 0, 0,0,0),
        mk(1,1,1,1,0,  0, 0,11, 0,0,0),  // R4 r0 written just ahead
        mk(1,1,1,0,0, 11,10,12, 0,1,0),  // non-writer with rd12
        mk(1,1,1,1,0, 12,12, 0, 0,0,0),  // R5 rd12 not write-enabled
        mk(1,1,0,1,1,  2, 0,13, 0,0,0),  // load r13
        mk(1,1,1,1,0, 13, 3,14, 1,0,0),  // R6 load-use on rs
        mk(1,1,1,1,0, 13, 3,14, 0,2,0),  // R7 held instr proceeds
        mk(1,1,0,1,1,  3, 0,15, 0,0,0),  // load r15
        mk(1,1,0,1,0, 17,15,16, 0,0,0),  // R5 rt=r15 unused: no stall
        mk(0,1,1,1,0, 16,16, 0, 0,0,0),  // R5 invalid slot
        mk(1,1,1,1,0, 16,16,18, 0,2,2),  // R2 over an empty slot
        mk(1,1,0,1,1,  0, 0,19, 0,0,0),  // load r19
        mk(1,1,1,1,0,  1,19,20, 1,0,0),  // R6 load-use on rt
        mk(1,1,1,1,0,  1,19,20, 0,0,2),  // R7
        mk(1,1,0,1,1,  0, 0, 0, 0,0,0),  // load to r0
        mk(1,1,1,1,0,  0, 0,21, 0,0,0),  // R4 no stall on r0
        mk(1,1,1,1,0, 21,21,22, 0,1,1)   // R1 both operands
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dec_valid, dec_use_rs, dec_use_rt, dec_wen, dec_load;
    logic [AW-1:0] dec_rs, dec_rt, dec_rd;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fwd_stall_unit #(.REG_AW(AW)) u_fwd_stall_unit (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rt(dec_rt),
        .dec_use_rs(dec_use_rs), .dec_use_rt(dec_use_rt), .dec_wen(dec_wen),
        .dec_load(dec_load), .dec_rd(dec_rd), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .stall(stall), .bubble(bubble)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] e);
        dec_valid  = e[24];
        dec_use_rs = e[23];
        dec_use_rt = e[22];
        dec_wen    = e[21];
        dec_load   = e[20];
        dec_rs     = e[19:15];
        dec_rt     = e[14:10];
        dec_rd     = e[9:5];
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0);
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset fwd_a", fwd_a, 0);
        check("R8 reset fwd_b", fwd_b, 0);
        check("R8 reset stall", stall, 0);
        check("R8 reset bubble", bubble, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            check($sformatf("R6 stall v%0d", i), stall, VEC[i][4]);
            check($sformatf("R6 bubble v%0d", i), bubble, VEC[i][4]);
            @(posedge clk);
            #1;
            check($sformatf("R1/R2/R7 fwd_a v%0d", i), fwd_a, VEC[i][3:2]);
            check($sformatf("R1/R2/R7 fwd_b v%0d", i), fwd_b, VEC[i][1:0]);
        end

        // R8: reset with a producer of r1 in flight
        @(negedge clk);
        drive(mk(1,1,1,1,1, 2,3,1, 0,0,0));   // load r1
        @(negedge clk);
        drive(mk(1,1,1,1,0, 1,1,4, 0,0,0));
        rst_n = 1'b0;
        #1;
        check("R8 stall held low in reset", stall, 0);
        @(posedge clk);
        #1;
        check("R8 fwd_a in reset", fwd_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(mk(1,1,1,1,0, 1,1,4, 0,0,0));
        #1;
        check("R8 no stall on pre-reset load", stall, 0);
        @(posedge clk);
        #1;
        check("R8 no bypass from pre-reset producer a", fwd_a, 0);
        check("R8 no bypass from pre-reset producer b", fwd_b, 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule